// File: doc/BRIEF.md
# Pseudo-Noise Whitening Serializer

This block produces a long pseudo-random bit stream and drives it onto a two-wire serial link made of a clock line and a data line, in the manner of an SPI transmitter. The generator is a 31-bit Fibonacci shift register. Its feedback is the XOR of the two oldest taps, at stages 31 and 28. The sequence has a period of 2^31 - 1 bits, about 35.8 minutes at 1 Mbit/s. Eight generator bits form one byte. A shifter sends each byte most significant bit first. The next byte is always ready when the current one ends, so bytes follow each other with no gap.

The bit rate is chosen by a small select input. At the intended 16 MHz system clock, codes 0 to 4 give 2, 1, 0.5, 0.25 and 0.125 Mbit/s. A new select value is taken only when a byte starts. A seed may be written while the link is stopped. When enable falls, the byte already under way is finished. The link then rests with both lines low and the generator state frozen. The output is a free-running serial line: it has no valid/ready handshake and no back-pressure, and the receiver samples the data line on every rising edge of the serial clock.

Top module: `pn_whiten_ser`

## Requirements
- R1: Generator state s[30:0] steps to {s[29:0], s[30]^s[27]}, and s[30] is the output bit. Each byte holds the next 8 output bits, and the first of them is sent first, on the first rising serial-clock edge of the byte.
- R2: A high seed_load writes seed_value into the generator. An all-zero seed_value writes the default seed 31'h1 instead, and the generator state is never zero.
- R3: The byte's rate code r sets each bit to 8<<r system clocks, split evenly between the low and high halves (bit times of 8, 16, 32, 64 and 128 clocks for codes 0 to 4). Codes 5, 6 and 7 act as code 4.
- R4: Each bit starts with sclk low for its first half and ends with sclk high. sclk is low whenever the link is stopped. The first rising edge comes half a bit time after the clock edge that samples enable high.
- R5: sdata changes only together with a falling edge of sclk or a byte start, and it holds steady while sclk is high.
- R6: Consecutive bytes are back to back. Two successive rising edges are spaced by the high half of the first bit plus the low half of the second.
- R7: A change of rate_sel during a byte does not affect that byte. The value present at the byte boundary sets the rate of the next byte.
- R8: Dropping enable lets the current byte complete. After that, sclk and sdata stay low. The next enable continues the sequence from the first bit that was not sent.
- R9: After reset, sclk and sdata are low and the generator holds the default seed 31'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Start or continue sending bytes |
| rate_sel | input | 3 | Bit-rate code, sampled at byte start |
| seed_load | input | 1 | Write seed_value into the generator |
| seed_value | input | 31 | New generator state (zero selects the default) |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench uses the default parameters: a base divide of 8 and five rates. With these values the slowest bit lasts only 128 system clocks, so all eight select codes can be swept, including the three above code 4. The bench sends whole bytes at each code and compares every bit against a bit-serial model of the generator. It also times every spacing between rising edges. Rate changes in both directions, a zero seed, a stop in the middle of a byte and a restart from the frozen state are covered too.

// File: rtl/pnser_pkg.sv
package pnser_pkg;
  localparam int unsigned LFSR_LEN = 31;
  localparam int unsigned TAP_HI   = 31;
  localparam int unsigned TAP_LO   = 28;
  localparam int unsigned BYTE_W   = 8;

  typedef logic [LFSR_LEN-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0]   byte_t;

  // Advance the Fibonacci register by one byte's worth of steps.
  function automatic lfsr_t lfsr_adv_byte(input lfsr_t s_in);
    lfsr_t s;
    s = s_in;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      s = {s[LFSR_LEN-2:0], s[TAP_HI-1] ^ s[TAP_LO-1]};
    end
    return s;
  endfunction

  // The next byte of output bits is the top of the register, oldest bit first.
  function automatic byte_t lfsr_head(input lfsr_t s);
    return s[LFSR_LEN-1 -: BYTE_W];
  endfunction
endpackage

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core
  import pnser_pkg::*;
#(
  parameter lfsr_t DEFAULT_SEED = lfsr_t'(1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seed_wr,
  input  lfsr_t seed_val,
  input  logic  adv,
  output byte_t head_o
);
  lfsr_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       st_q <= DEFAULT_SEED;
    else if (seed_wr) st_q <= (seed_val == '0) ? DEFAULT_SEED : seed_val;
    else if (adv)     st_q <= lfsr_adv_byte(st_q);
  end

  assign head_o = lfsr_head(st_q);

  assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/pn_bit_timer.sv
module pn_bit_timer #(
  parameter int unsigned BASE_DIV  = 8,
  parameter int unsigned NUM_RATES = 5,
  parameter int unsigned RSEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [RSEL_W-1:0] rate_sel,
  output logic              sclk_o,
  output logic              bit_end_o
);
  localparam int unsigned HALF0   = BASE_DIV / 2;
  localparam int unsigned MAX_DIV = BASE_DIV << (NUM_RATES - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV) + 1;
  localparam logic [RSEL_W-1:0] TOP_SEL = RSEL_W'(NUM_RATES - 1);

  logic [RSEL_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt_q, half_w, last_w;
  logic              sclk_q;

  assign half_w    = CNT_W'(HALF0) << rate_q;
  assign last_w    = (half_w << 1) - CNT_W'(1);
  assign bit_end_o = run && (cnt_q == last_w);
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (load) begin
      rate_q <= (rate_sel > TOP_SEL) ? TOP_SEL : rate_sel;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (run) begin
      if (bit_end_o) begin
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == half_w - CNT_W'(1)) sclk_q <= 1'b1;
      end
    end else begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end
  end

  assert_cnt_in_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= last_w);
  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sclk_q);
  assert_rate_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load |=> $stable(rate_q));
endmodule

// File: rtl/pn_byte_shift.sv
module pn_byte_shift
  import pnser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  logic  run,
  input  byte_t byte_i,
  output logic  sdata_o,
  output logic  last_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  byte_t            sh_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= byte_i;
      idx_q <= '0;
    end else if (step) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign sdata_o = run & sh_q[BYTE_W-1];
  assign last_o  = (idx_q == IDX_W'(BYTE_W - 1));

  assert_idx_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(idx_q) && $stable(sh_q));
endmodule

// File: rtl/pn_whiten_ser.sv
module pn_whiten_ser
  import pnser_pkg::*;
#(
  parameter int unsigned BASE_DIV     = 8,
  parameter int unsigned NUM_RATES    = 5,
  parameter int unsigned RSEL_W       = 3,
  parameter logic [30:0] DEFAULT_SEED = 31'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              seed_load,
  input  logic [30:0]       seed_value,
  output logic              sclk,
  output logic              sdata
);
  logic  active_q, load, stop, bit_end, last_bit;
  byte_t head;

  assign load = enable && (!active_q || (bit_end && last_bit));
  assign stop = active_q && bit_end && last_bit && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n)    active_q <= 1'b0;
    else if (load) active_q <= 1'b1;
    else if (stop) active_q <= 1'b0;
  end

  pn_lfsr_core #(.DEFAULT_SEED(DEFAULT_SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .seed_wr(seed_load), .seed_val(seed_value),
    .adv(load), .head_o(head)
  );

  pn_bit_timer #(.BASE_DIV(BASE_DIV), .NUM_RATES(NUM_RATES), .RSEL_W(RSEL_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(load), .run(active_q), .rate_sel(rate_sel),
    .sclk_o(sclk), .bit_end_o(bit_end)
  );

  pn_byte_shift shift_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(bit_end), .run(active_q),
    .byte_i(head), .sdata_o(sdata), .last_o(last_bit)
  );

  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sdata));
  assert_stop_rests_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active_q && !sclk && !sdata);
endmodule

// File: tb/pn_whiten_ser_tb_top.sv
module pn_whiten_ser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic        seed_load = 1'b0;
  logic [30:0] seed_value = '0;
  logic        sclk, sdata;

  always #2 clk = ~clk;

  pn_whiten_ser dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .seed_load(seed_load), .seed_value(seed_value), .sclk(sclk), .sdata(sdata)
  );

  int tests = 0;
  int fails = 0;
  logic [30:0] m_s = 31'h1;
  logic prev_s = 1'b0, held = 1'b0, rose = 1'b0, stab_bad = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hp(input logic [2:0] r);
    return 4 << ((r > 3'd4) ? 4 : int'(r));
  endfunction

  function automatic logic model_bit();
    logic b;
    b   = m_s[30];
    m_s = {m_s[29:0], m_s[30] ^ m_s[27]};
    return b;
  endfunction

  task automatic tick();
    @(negedge clk);
    rose = sclk && !prev_s;
    if (sclk && prev_s && sdata != held) stab_bad = 1'b1;
    if (rose) held = sdata;
    prev_s = sclk;
  endtask

  task automatic load_seed(input logic [30:0] v);
    seed_value = v;
    seed_load  = 1'b1;
    tick();
    seed_load = 1'b0;
    m_s = (v == '0) ? 31'h1 : v;
  endtask

  // Send nbytes; rate r0 until byte chg_byte, then r1 is applied mid-byte.
  task automatic run(input int nbytes, input logic [2:0] r0, input int chg_byte,
                     input logic [2:0] r1, input string dreq);
    int hp_prev = 0;
    int rises;
    rate_sel = r0;
    enable   = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      int hp_cur = hp((chg_byte >= 0 && b > chg_byte) ? r1 : r0);
      for (int k = 0; k < 8; k++) begin
        int gap = 0;
        logic eb;
        do begin tick(); gap++; end while (!rose);
        eb = model_bit();
        chk(sdata == eb, dreq, int'(sdata), int'(eb));
        if (b == 0 && k == 0)
          chk(gap == hp_cur + 1, "R4 first edge", gap, hp_cur + 1);
        else if (k > 0)
          chk(gap == 2 * hp_cur, "R3 bit time", gap, 2 * hp_cur);
        else if (hp_prev != hp_cur)
          chk(gap == hp_prev + hp_cur, "R7 rate at boundary", gap, hp_prev + hp_cur);
        else
          chk(gap == hp_prev + hp_cur, "R6 no gap", gap, hp_prev + hp_cur);
        if (!(b == 0 && k == 0)) begin
          chk(!stab_bad, "R5 steady high", int'(stab_bad), 0);
          stab_bad = 1'b0;
        end
        if (b == chg_byte && k == 3) rate_sel = r1;
        if (b == nbytes - 1 && k == 0) enable = 1'b0;
        hp_prev = hp_cur;
      end
    end
    rises = 0;
    repeat (2 * 128 + 40) begin tick(); if (rose) rises++; end
    chk(!stab_bad, "R5 steady high", int'(stab_bad), 0);
    stab_bad = 1'b0;
    chk(rises == 0, "R8 no extra bits", rises, 0);
    chk(!sclk && !sdata, "R8 rest low", int'({sclk, sdata}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(!sclk && !sdata, "R9 reset outputs", int'({sclk, sdata}), 0);
    run(2, 3'd0, -1, 3'd0, "R9 default seed");
    for (int r = 0; r < 8; r++) begin
      load_seed(31'h2A5F_1C3 * (r + 3) ^ 31'h4000_0000);
      run(2, 3'(r), -1, 3'(r), "R1 sequence");
    end
    load_seed(31'h0);
    run(1, 3'd2, -1, 3'd2, "R2 zero seed");
    load_seed(31'h7FFF_FFFF);
    run(3, 3'd1, 0, 3'd3, "R1 sequence");
    run(3, 3'd3, 0, 3'd0, "R1 sequence");
    run(1, 3'd0, -1, 3'd0, "R8 resume");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule